// File: doc/BRIEF.md
# Braided Block Encoder with Selected-Parity Re-encoding

This block turns a square message of k×k bits into one braided block codeword and sends it out as a serial bit stream. Two identical systematic (n,k) cyclic encoders, each a linear feedback shift register of n−k stages, do the work. The first encoder codes each k-bit row of the message. A diagonal interleaver that adds no stuff bits reorders the message so that every permuted block holds exactly one bit of every row. The second encoder codes each permuted block, and only its parity is kept.

A fixed set of parity positions is then taken from each first-encoder codeword. These bits are gathered so that block i holds the i-th chosen bit of every codeword, in codeword order. The second encoder runs again on each gathered block and adds a third parity section. The second encoder hardware handles both the permuted message blocks and the gathered parity blocks. It works on the gathered blocks while the second section is being sent, so the output stream has no gaps.

The default configuration uses the (15,7) code with generator 1 + x⁴ + x⁶ + x⁷ + x⁸, k = 7, and chosen positions 8, 9, 10 and 12. This gives a 193-bit codeword for each 49-bit message.

Top module: `braid_enc`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Each accepted message produces exactly k·n + k·(n−k) + n_pr·(n−k) output transfers, 193 in the default configuration. The sections come in the order R3, R4, R5, and `out_last` is 1 on the final transfer only.
- R3: Section one holds k words of n bits. Word j carries message bits `msg_in[j*k+t]` for t = 0…k−1, then n−k parity bits. The word is valid when the polynomial Σ c_p·x^(n−1−p) is divisible by the generator, with c_p the bit at word position p and position 0 sent first.
- R4: Section two holds k parity groups of n−k bits. Group r is the parity, under the R3 rule, of a permuted block whose bit c is bit c of message row (r − c) mod k. Each permuted block therefore has one bit from every row.
- R5: Section three holds n_pr parity groups of n−k bits. Group i is the parity, under the R3 rule, of a block whose bit j is the bit at word position `SEL_POS[i]` of section-one word j. The default positions are 8, 9, 10 and 12.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1, with `out_bit` and `out_last` unchanged.
- R7: A message is accepted only when `in_ready` is 1, and `in_ready` stays 0 while a frame is being sent. Any `in_valid` and `msg_in` activity during a frame leaves the frame unchanged.
- R8: `out_valid` rises on the cycle after a message is accepted. `in_ready` is 1, and `out_valid` is 0, on the cycle after the last transfer.
- R9: Each second-encoder block from R4 or R5, followed by its n−k output parity bits, forms a word that satisfies the R3 divisibility rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message on `msg_in` is offered |
| in_ready | output | 1 | Encoder is idle and will accept a message |
| msg_in | input | K*K | Message; bit j*K+t is bit t of row j |
| out_valid | output | 1 | `out_bit` holds a codeword bit |
| out_ready | input | 1 | Receiver takes the bit this cycle |
| out_bit | output | 1 | Serial codeword bit |
| out_last | output | 1 | Marks the final bit of the codeword |

## Verification
The hardest case to reach is the third parity section. Its content depends on chosen parity bits of every first-section word, and an error there stays hidden unless those particular bits are non-zero in a pattern that reaches many gathered blocks. The stimulus therefore sends every weight-one message and a spread of weight-two messages, whose low-weight first-section words set the chosen positions sparsely. It adds random messages under random back-pressure, which also stalls the stream across every section boundary. A frame during which the bench keeps offering a different message checks that the busy encoder ignores its input.

// File: rtl/braid_pkg.sv
package braid_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_MPAR = 2'd2,
        PH_XPAR = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] blk;
        logic [CNT_W-1:0] pos;
    } seq_t;

    // Row of the message that supplies column col of permuted block row.
    function automatic int diag_src(input int row, input int col, input int k);
        return (row - col + k) % k;
    endfunction

    function automatic int frame_bits(input int k, input int n, input int npr);
        return k * n + k * (n - k) + npr * (n - k);
    endfunction

endpackage

// File: rtl/braid_lfsr.sv
module braid_lfsr #(
    parameter int         NK    = 8,
    parameter logic [NK-1:0] GPOLY = 8'hD1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          feed,
    input  logic          din,
    output logic [NK-1:0] rem_o
);

    logic          fb;
    logic [NK-1:0] rem_nxt;

    // Division of x^(n-k)*m(x) by g(x), highest-degree message bit first.
    always_comb begin
        fb      = din ^ rem_o[NK-1];
        rem_nxt = {rem_o[NK-2:0], 1'b0} ^ (fb ? GPOLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem_o <= '0;
        end else if (feed) begin
            rem_o <= rem_nxt;
        end
    end

endmodule

// File: rtl/braid_seq.sv
module braid_seq
    import braid_pkg::*;
#(
    parameter int K   = 7,
    parameter int N   = 15,
    parameter int NPR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic adv,
    output seq_t cur,
    output logic at_last
);

    localparam logic [CNT_W-1:0] CW_END   = CNT_W'(N - 1);
    localparam logic [CNT_W-1:0] PAR_END  = CNT_W'(N - K - 1);
    localparam logic [CNT_W-1:0] MBLK_END = CNT_W'(K - 1);
    localparam logic [CNT_W-1:0] XBLK_END = CNT_W'(NPR - 1);

    logic [CNT_W-1:0] pos_end;
    logic [CNT_W-1:0] blk_end;
    logic             blk_done;
    logic             sec_done;
    phase_e           nxt_ph;

    always_comb begin
        pos_end  = (cur.ph == PH_DATA) ? CW_END : PAR_END;
        blk_end  = (cur.ph == PH_XPAR) ? XBLK_END : MBLK_END;
        blk_done = (cur.pos == pos_end);
        sec_done = blk_done && (cur.blk == blk_end);
        case (cur.ph)
            PH_DATA: nxt_ph = PH_MPAR;
            PH_MPAR: nxt_ph = PH_XPAR;
            default: nxt_ph = PH_IDLE;
        endcase
    end

    assign at_last = (cur.ph == PH_XPAR) && sec_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{ph: PH_IDLE, blk: '0, pos: '0};
        end else if (cur.ph == PH_IDLE) begin
            if (start) begin
                cur.ph <= PH_DATA;
            end
        end else if (adv) begin
            if (!blk_done) begin
                cur.pos <= cur.pos + 1'b1;
            end else begin
                cur.pos <= '0;
                if (sec_done) begin
                    cur.blk <= '0;
                    cur.ph  <= nxt_ph;
                end else begin
                    cur.blk <= cur.blk + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/braid_enc.sv
module braid_enc
    import braid_pkg::*;
#(
    parameter int              K       = 7,
    parameter int              N       = 15,
    parameter int              NPR     = 4,
    parameter logic [N-K-1:0]  GPOLY   = 8'hD1,
    parameter int              SEL_POS [NPR] = '{8, 9, 10, 12}
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [K*K-1:0] msg_in,
    output logic           out_valid,
    input  logic           out_ready,
    output logic           out_bit,
    output logic           out_last
);

    localparam int NK    = N - K;
    localparam int MSGW  = K * K;
    localparam int MW    = $clog2(MSGW);
    localparam int NKB   = $clog2(NK);
    localparam int KB    = $clog2(K);
    localparam int PB    = $clog2(NPR);
    localparam int FBW   = $clog2(K + 1);
    localparam int FLW   = $clog2(NPR + 1);

    seq_t            cur;
    logic            fire;
    logic            start;
    logic [MSGW-1:0] msg_q;

    logic [NK-1:0]   pbuf [K];
    logic [NK-1:0]   xbuf [NPR];
    logic [NPR-1:0]  selq [K];

    logic [FBW-1:0]  fbit;
    logic [FLW-1:0]  fblk;

    logic            a_feed, a_clr, a_din;
    logic            b_feed, b_clr, b_din;
    logic            cap_m, cap_x;
    logic [NK-1:0]   a_rem, b_rem;
    logic [NPR-1:0]  sel_bit;
    logic [MW-1:0]   a_idx, b_idx;
    logic [KB-1:0]   blk_k;
    int              blk_i, pos_i;

    assign in_ready  = (cur.ph == PH_IDLE);
    assign out_valid = (cur.ph != PH_IDLE);
    assign start     = in_valid && in_ready;
    assign fire      = out_valid && out_ready;
    assign blk_i     = int'(cur.blk);
    assign pos_i     = int'(cur.pos);
    assign blk_k     = cur.blk[KB-1:0];

    braid_seq #(.K(K), .N(N), .NPR(NPR)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .adv     (fire),
        .cur     (cur),
        .at_last (out_last)
    );

    // First encoder: rows of the message.
    braid_lfsr #(.NK(NK), .GPOLY(GPOLY)) u_enc_a (
        .clk   (clk),
        .rst   (rst),
        .clr   (a_clr),
        .feed  (a_feed),
        .din   (a_din),
        .rem_o (a_rem)
    );

    // Second encoder: permuted rows, then gathered chosen parity.
    braid_lfsr #(.NK(NK), .GPOLY(GPOLY)) u_enc_b (
        .clk   (clk),
        .rst   (rst),
        .clr   (b_clr),
        .feed  (b_feed),
        .din   (b_din),
        .rem_o (b_rem)
    );

    // Chosen parity positions read out of the first encoder's remainder.
    for (genvar s = 0; s < NPR; s++) begin : g_sel
        assign sel_bit[s] = a_rem[N - 1 - SEL_POS[s]];
    end

    always_comb begin
        a_feed  = 1'b0;
        a_clr   = 1'b0;
        a_din   = 1'b0;
        b_feed  = 1'b0;
        b_clr   = 1'b0;
        b_din   = 1'b0;
        cap_m   = 1'b0;
        cap_x   = 1'b0;
        out_bit = 1'b0;
        a_idx   = '0;
        b_idx   = '0;
        case (cur.ph)
            PH_DATA: begin
                if (cur.pos < CNT_W'(K)) begin
                    a_idx   = MW'(blk_i * K + pos_i);
                    b_idx   = MW'(diag_src(blk_i, pos_i, K) * K + pos_i);
                    a_din   = msg_q[a_idx];
                    b_din   = msg_q[b_idx];
                    out_bit = a_din;
                    a_feed  = fire;
                    b_feed  = fire;
                end else begin
                    out_bit = a_rem[NKB'(N - 1 - pos_i)];
                    a_clr   = fire && (cur.pos == CNT_W'(N - 1));
                    cap_m   = fire && (cur.pos == CNT_W'(K));
                    b_clr   = cap_m;
                end
            end
            PH_MPAR: begin
                out_bit = pbuf[blk_k][NKB'(NK - 1 - pos_i)];
                if (fblk < FLW'(NPR)) begin
                    if (fbit < FBW'(K)) begin
                        b_din  = selq[fbit[KB-1:0]][fblk[PB-1:0]];
                        b_feed = fire;
                    end else begin
                        cap_x = fire;
                        b_clr = fire;
                    end
                end
            end
            PH_XPAR: begin
                out_bit = xbuf[cur.blk[PB-1:0]][NKB'(NK - 1 - pos_i)];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            fbit  <= '0;
            fblk  <= '0;
        end else begin
            if (start) begin
                msg_q <= msg_in;
                fbit  <= '0;
                fblk  <= '0;
            end
            if (b_feed && (cur.ph == PH_MPAR)) begin
                fbit <= fbit + 1'b1;
            end
            if (cap_x) begin
                fbit <= '0;
                fblk <= fblk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (cap_m) begin
            pbuf[blk_k] <= b_rem;
        end
        if (cap_x) begin
            xbuf[fblk[PB-1:0]] <= b_rem;
        end
        if (a_clr) begin
            selq[blk_k] <= sel_bit;
        end
    end

endmodule

// File: rtl/braid_chk.sv
module braid_chk #(
    parameter int TOTAL = 193
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_bit,
    input logic out_last
);

    int fire_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_cnt <= 0;
        end else if (out_valid && out_ready) begin
            fire_cnt <= out_last ? 0 : fire_cnt + 1;
        end
    end

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

    assert_last_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_frame_length_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |-> (fire_cnt == TOTAL - 1));

    assert_busy_closed_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_start_next_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    assert_release_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

endmodule

bind braid_enc braid_chk #(.TOTAL(K * N + K * (N - K) + NPR * (N - K))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last)
);

// File: tb/tb_braid_enc.sv
module tb_braid_enc;

    localparam int CLK_PERIOD = 10;
    localparam int K     = 7;
    localparam int N     = 15;
    localparam int NK    = 8;
    localparam int NPR   = 4;
    localparam int TOTAL = 193;
    localparam int SEC2  = 105;
    localparam int SEC3  = 161;
    localparam logic [8:0] GFULL = 9'h1D1;
    localparam int SELP [NPR] = '{8, 9, 10, 12};

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [48:0] msg_in;
    logic        out_valid;
    logic        out_ready;
    logic        out_bit;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit rdy_rand = 1'b0;

    bit exp_q [$];
    bit obs_q [$];

    bit prev_stall = 1'b0;
    bit prev_bit   = 1'b0;
    bit prev_last  = 1'b0;
    bit prev_end   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    braid_enc dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .msg_in    (msg_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    // Long-division remainder of a 7-bit block; bit t has degree 14-t.
    function automatic logic [7:0] rem_of(input logic [6:0] b);
        logic [14:0] v;
        v = '0;
        for (int t = 0; t < 7; t++) v[14 - t] = b[t];
        for (int d = 14; d >= 8; d--) if (v[d]) v = v ^ (15'(GFULL) << (d - 8));
        return v[7:0];
    endfunction

    function automatic bit is_word(input logic [14:0] c);
        logic [14:0] v;
        v = '0;
        for (int t = 0; t < 15; t++) v[14 - t] = c[t];
        for (int d = 14; d >= 8; d--) if (v[d]) v = v ^ (15'(GFULL) << (d - 8));
        return (v[7:0] == 8'h00);
    endfunction

    task automatic push_par(input logic [6:0] b);
        logic [7:0] r;
        r = rem_of(b);
        for (int q = 0; q < 8; q++) exp_q.push_back(r[7 - q]);
    endtask

    task automatic load_expected(input logic [48:0] m);
        logic [14:0] cw [K];
        logic [6:0]  blk;
        logic [7:0]  r;
        for (int j = 0; j < K; j++) begin
            for (int t = 0; t < K; t++) blk[t] = m[j * K + t];
            r = rem_of(blk);
            for (int t = 0; t < K; t++) cw[j][t] = blk[t];
            for (int q = 0; q < 8; q++) cw[j][K + q] = r[7 - q];
            for (int p = 0; p < N; p++) exp_q.push_back(cw[j][p]);
        end
        for (int rr = 0; rr < K; rr++) begin
            for (int c = 0; c < K; c++) blk[c] = m[((rr - c + K) % K) * K + c];
            push_par(blk);
        end
        for (int i = 0; i < NPR; i++) begin
            for (int j = 0; j < K; j++) blk[j] = cw[j][SELP[i]];
            push_par(blk);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compares every transfer against the model queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                checks++;
                if (!(out_valid && out_bit == prev_bit && out_last == prev_last)) begin
                    fails++;
                    $display("FAIL R6 stall: valid=%0b bit=%0b last=%0b expected valid=1 bit=%0b last=%0b",
                             out_valid, out_bit, out_last, prev_bit, prev_last);
                end
            end
            if (prev_end) begin
                checks++;
                if (!(in_ready && !out_valid)) begin
                    fails++;
                    $display("FAIL R8 after last: in_ready=%0b out_valid=%0b expected 1 0",
                             in_ready, out_valid);
                end
            end
            prev_end = 1'b0;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R2 extra transfer: got bit %0b expected none", out_bit);
                end else begin
                    bit e;
                    bit el;
                    int idx;
                    idx = obs_q.size();
                    e  = exp_q.pop_front();
                    el = (exp_q.size() == 0);
                    checks++;
                    if (out_bit != e) begin
                        fails++;
                        if (idx < SEC2)
                            $display("FAIL R3 bit %0d: got %0b expected %0b", idx, out_bit, e);
                        else if (idx < SEC3)
                            $display("FAIL R4 bit %0d: got %0b expected %0b", idx, out_bit, e);
                        else
                            $display("FAIL R5 bit %0d: got %0b expected %0b", idx, out_bit, e);
                    end
                    checks++;
                    if (out_last != el) begin
                        fails++;
                        $display("FAIL R2 last at bit %0d: got %0b expected %0b", idx, out_last, el);
                    end
                    prev_end = out_last;
                end
                obs_q.push_back(out_bit);
            end
            prev_stall = out_valid && !out_ready;
            prev_bit   = out_bit;
            prev_last  = out_last;
        end
    end

    // Receiver: always ready or randomly stalling.
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = rdy_rand ? ($urandom() % 4 != 0) : 1'b1;
        end
    end

    task automatic check_words(input logic [48:0] m);
        logic [14:0] w;
        for (int j = 0; j < K; j++) begin
            for (int p = 0; p < N; p++) w[p] = obs_q[j * N + p];
            checks++;
            if (!is_word(w)) begin
                fails++;
                $display("FAIL R3 word %0d not a codeword: got %h expected zero syndrome", j, w);
            end
        end
        for (int rr = 0; rr < K; rr++) begin
            for (int c = 0; c < K; c++) w[c] = m[((rr - c + K) % K) * K + c];
            for (int q = 0; q < NK; q++) w[K + q] = obs_q[SEC2 + rr * NK + q];
            checks++;
            if (!is_word(w)) begin
                fails++;
                $display("FAIL R9 permuted block %0d: got %h expected zero syndrome", rr, w);
            end
        end
        for (int i = 0; i < NPR; i++) begin
            for (int j = 0; j < K; j++) w[j] = obs_q[j * N + SELP[i]];
            for (int q = 0; q < NK; q++) w[K + q] = obs_q[SEC3 + i * NK + q];
            checks++;
            if (!is_word(w)) begin
                fails++;
                $display("FAIL R9 gathered block %0d: got %h expected zero syndrome", i, w);
            end
        end
    endtask

    task automatic run_frame(input logic [48:0] m, input bit noisy);
        load_expected(m);
        obs_q.delete();
        @(posedge clk);
        #1;
        while (!in_ready) begin
            @(posedge clk);
            #1;
        end
        in_valid = 1'b1;
        msg_in   = m;
        @(posedge clk);
        #1;
        if (noisy) begin
            // R7: offer a different message while the frame runs.
            msg_in = ~m;
            for (int c = 0; c < 40; c++) begin
                checks++;
                if (in_ready) begin
                    fails++;
                    $display("FAIL R7 busy cycle %0d: in_ready got 1 expected 0", c);
                end
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        while (obs_q.size() < TOTAL) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 frame short: got %0d bits expected %0d", TOTAL - exp_q.size(), TOTAL);
            exp_q.delete();
        end
        check_words(m);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run got no end, expected completion");
        report();
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        msg_in   = '0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (!(out_valid == 1'b0 && in_ready == 1'b1 && out_last == 1'b0)) begin
            fails++;
            $display("FAIL R1 reset: valid=%0b ready=%0b last=%0b expected 0 1 0",
                     out_valid, in_ready, out_last);
        end
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (!(out_valid == 1'b0 && in_ready == 1'b1 && out_last == 1'b0)) begin
            fails++;
            $display("FAIL R1 after reset: valid=%0b ready=%0b last=%0b expected 0 1 0",
                     out_valid, in_ready, out_last);
        end

        // R3 R4 R5 R9: all weight-one messages.
        for (int a = 0; a < 49; a++) run_frame(49'(1) << a, 1'b0);

        // R3 R4 R5 R9: a spread of weight-two messages.
        for (int a = 0; a < 49; a++)
            for (int b = a + 1; b < 49; b++)
                if ((a + b) % 7 == 3) run_frame((49'(1) << a) | (49'(1) << b), 1'b0);

        // R7: busy encoder ignores offered messages.
        run_frame(49'h1_2345_6789_ABCD, 1'b1);
        run_frame(49'h0_F0F0_0F0F_3C3C, 1'b1);

        // R6 R8: random messages under random back-pressure.
        rdy_rand = 1'b1;
        for (int i = 0; i < 40; i++) run_frame(49'({$urandom(), $urandom()}), 1'b0);
        run_frame({49{1'b1}}, 1'b0);
        rdy_rand = 1'b0;
        run_frame('0, 1'b0);

        repeat (5) @(posedge clk);
        report();
    end

endmodule